// File: doc/BRIEF.md
# Nibble-Mode Reverse-Channel Receiver

This block is the host half of a parallel-port reverse transfer in which the peripheral returns data four bits at a time over its status lines. Given a byte count and a start pulse, it runs one request/acknowledge handshake per half-byte. It assembles each byte from two halves and hands it out with a single-cycle strobe. It ends with a done flag, or with one of two error flags if the peripheral stalls. Mode negotiation is handled by other logic before the block is started.

Each half-byte exchange works as follows. The block pulls nAutoFd low and waits for the peripheral to drop nAck. It then captures the four status lines and raises nAutoFd again. Finally it waits for nAck to go high before the next request. The selection and strobe outputs stay high for the whole exchange. All five status inputs are passed through a two-stage synchronizer before any decision is made on them.

Top module: `nibble_rx`

## Requirements
- R1: After reset, n_autofd, n_selectin and n_strobe are high, and byte_valid, done, timeout and io_error are low.
- R2: A start pulse with a nonzero byte_count, taken while idle, drives n_autofd low to request a half-byte. n_selectin and n_strobe stay high at all times.
- R3: Half-byte bits come from the synchronized status lines as follows: bit 0 from n_fault, bit 1 from select, bit 2 from perror and bit 3 from busy. The first half of each byte fills byte_data[3:0] and the second half fills byte_data[7:4].
- R4: Once the synchronized nAck is seen low, n_autofd goes high. n_autofd is not driven low again until nAck has been seen high again.
- R5: byte_valid is high for exactly one cycle per byte, only after the second half is captured. Exactly byte_count bytes are delivered, and done is then set.
- R6: The wait for the first half of a byte may last up to IDLE_LIMIT cycles. The wait for a second half, and every wait for nAck to rise, may last up to RESP_LIMIT cycles.
- R7: If a half-byte wait expires, the transfer ends, timeout is set, n_autofd returns high and no byte is produced for the unfinished pair.
- R8: If the nAck release after the last byte's second half is missed, io_error is set (not timeout). A missed release at any earlier point sets timeout.
- R9: A start pulse while a transfer is in progress has no effect on the byte count or on the bytes delivered.
- R10: A start pulse with byte_count of zero sets done on the next cycle and issues no request.
- R11: A start pulse taken while idle clears done, timeout and io_error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| byte_count | input | CNT_W | Number of bytes to receive |
| n_ack | input | 1 | Peripheral acknowledge, active low |
| busy | input | 1 | Status line, half-byte bit 3 |
| perror | input | 1 | Status line, half-byte bit 2 |
| select | input | 1 | Status line, half-byte bit 1 |
| n_fault | input | 1 | Status line, half-byte bit 0 |
| n_autofd | output | 1 | Half-byte request, active low |
| n_selectin | output | 1 | Held high |
| n_strobe | output | 1 | Held high |
| byte_valid | output | 1 | One-cycle strobe for byte_data |
| byte_data | output | 8 | Assembled byte |
| done | output | 1 | Transfer completed normally |
| timeout | output | 1 | Transfer ended on an expired wait |
| io_error | output | 1 | Final nAck release missed |

## Verification
The bench builds the block with IDLE_LIMIT of 64, RESP_LIMIT of 16 and CNT_W of 8. With these values, a peripheral delay of about 40 cycles sits between the two limits. The same delay therefore succeeds on a first half-byte and times out on a second one, which makes the two wait budgets separately observable. The small limits also let a peripheral that never answers hit every abort path within a few dozen cycles, including the io_error case and the earlier-release timeout case.

// File: rtl/nibble_rx.sv
module nibble_rx #(
  parameter int CNT_W      = 16,
  parameter int IDLE_LIMIT = 4000,
  parameter int RESP_LIMIT = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             n_ack,
  input  logic             busy,
  input  logic             perror,
  input  logic             select,
  input  logic             n_fault,
  output logic             n_autofd,
  output logic             n_selectin,
  output logic             n_strobe,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             done,
  output logic             timeout,
  output logic             io_error
);

  localparam int MAXL = (IDLE_LIMIT > RESP_LIMIT) ? IDLE_LIMIT : RESP_LIMIT;
  localparam int TW   = $clog2(MAXL + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_REL} st_t;

  st_t              state;
  logic [4:0]       meta, stat;
  logic             half;
  logic [TW-1:0]    timer, lim;
  logic [CNT_W-1:0] rem;
  logic [3:0]       lo;

  wire       ack_lo  = !stat[4];
  wire [3:0] nib     = stat[3:0];
  wire       last    = half && (rem == '0);
  wire       expired = (timer == lim);

  assign lim        = (state == S_REQ && !half) ? TW'(IDLE_LIMIT - 1) : TW'(RESP_LIMIT - 1);
  assign n_autofd   = (state != S_REQ);
  assign n_selectin = 1'b1;
  assign n_strobe   = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= 5'b10000;
      stat <= 5'b10000;
    end else begin
      meta <= {n_ack, busy, perror, select, n_fault};
      stat <= meta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      half       <= 1'b0;
      timer      <= '0;
      rem        <= '0;
      lo         <= '0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      done       <= 1'b0;
      timeout    <= 1'b0;
      io_error   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          done     <= (byte_count == '0);
          timeout  <= 1'b0;
          io_error <= 1'b0;
          half     <= 1'b0;
          timer    <= '0;
          rem      <= byte_count;
          if (byte_count != '0) state <= S_REQ;
        end
        S_REQ: if (ack_lo) begin
          timer <= '0;
          state <= S_REL;
          if (!half) lo <= nib;
          else begin
            byte_data  <= {nib, lo};
            byte_valid <= 1'b1;
            rem        <= rem - 1'b1;
          end
        end else if (expired) begin
          timeout <= 1'b1;
          state   <= S_IDLE;
        end else timer <= timer + 1'b1;
        S_REL: if (!ack_lo) begin
          timer <= '0;
          half  <= !half;
          if (last) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else state <= S_REQ;
        end else if (expired) begin
          if (last) io_error <= 1'b1;
          else      timeout  <= 1'b1;
          state <= S_IDLE;
        end else timer <= timer + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_valid_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> n_autofd);

  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> n_autofd);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, timeout, io_error}) <= 1);

  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(timer) < MAXL);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REQ && start && !ack_lo) |=> $stable(rem));

endmodule

// File: tb/test_nibble_rx.sv
`timescale 1ns/1ps
module test_nibble_rx;
  localparam int CW = 8, IL = 64, RL = 16, NEVER = 10000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CW-1:0] byte_count = '0;
  logic n_ack = 1, busy = 0, perror = 0, select = 0, n_fault = 0;
  logic n_autofd, n_selectin, n_strobe, byte_valid, done, timeout, io_error;
  logic [7:0] byte_data;

  always #2.5 clk = !clk;

  nibble_rx #(.CNT_W(CW), .IDLE_LIMIT(IL), .RESP_LIMIT(RL)) i_nibble_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .n_ack(n_ack), .busy(busy), .perror(perror), .select(select), .n_fault(n_fault),
    .n_autofd(n_autofd), .n_selectin(n_selectin), .n_strobe(n_strobe),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .done(done), .timeout(timeout), .io_error(io_error));

  int checks = 0, fails = 0;
  logic [7:0] pat [8];
  logic [7:0] exp_q [$];
  int nvalid = 0, viol = 0, viol_ctl = 0, waited = 0;
  int d_lo = 1, d_hi = 1, r_lo = 1, r_hi = 1;
  logic m_rst = 1;
  int m_state = 0, m_cnt = 0, m_idx = 0;
  logic m_half = 0, m_seen_hi = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // peripheral model
  always @(negedge clk) begin
    if (m_rst) begin
      n_ack = 1; m_state = 0; m_cnt = 0; m_half = 0; m_idx = 0; m_seen_hi = 0;
    end else if (m_state == 0) begin
      if (!n_autofd) begin
        if (m_cnt >= (m_half ? d_hi : d_lo)) begin
          {busy, perror, select, n_fault} = m_half ? pat[m_idx][7:4] : pat[m_idx][3:0];
          n_ack = 0; m_state = 1; m_cnt = 0; m_seen_hi = 0;
        end else m_cnt++;
      end
    end else begin
      if (n_autofd) m_seen_hi = 1;
      else if (m_seen_hi) viol++;
      if (n_autofd) begin
        if (m_cnt >= (m_half ? r_hi : r_lo)) begin
          n_ack = 1; m_state = 0; m_cnt = 0;
          if (m_half) m_idx++;
          m_half = !m_half;
        end else m_cnt++;
      end
    end
    if (!n_selectin || !n_strobe) viol_ctl++;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && byte_valid) begin
      nvalid++;
      if (exp_q.size() == 0) chk(0, "R5 unexpected byte", int'(byte_data), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(byte_data == e, "R3 byte value", int'(byte_data), int'(e));
      end
    end
  end

  task automatic xfer(input int n, input int nexp, input bit poke);
    m_rst = 1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    m_rst = 0;
    for (int i = 0; i < nexp; i++) exp_q.push_back(pat[i]);
    nvalid = 0; viol = 0;
    start = 1; byte_count = CW'(n);
    @(negedge clk);
    start = 0;
    waited = 0;
    for (int i = 0; i < 2000; i++) begin
      if (poke && i == 10) begin start = 1; byte_count = 1; end
      else start = 0;
      @(negedge clk);
      waited++;
      if (done || timeout || io_error) break;
    end
    start = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h0F; pat[3] = 8'hF0;
    pat[4] = 8'h69; pat[5] = 8'h81; pat[6] = 8'h00; pat[7] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(n_autofd && n_selectin && n_strobe, "R1 control lines", {n_autofd, n_selectin, n_strobe}, 7);
    chk(!byte_valid && !done && !timeout && !io_error, "R1 flags", {byte_valid, done, timeout, io_error}, 0);

    // R2 R3 R5: fast transfer of eight bytes
    d_lo = 1; d_hi = 1; r_lo = 1; r_hi = 1;
    xfer(8, 8, 0);
    chk(done && !timeout && !io_error, "R5 done", {done, timeout, io_error}, 4);
    chk(nvalid == 8, "R5 byte count", nvalid, 8);
    chk(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 0);
    chk(viol_ctl == 0, "R2 select/strobe high", viol_ctl, 0);

    // R4: slow release, no new request while nAck low
    d_lo = 3; d_hi = 3; r_lo = 10; r_hi = 10;
    xfer(3, 3, 0);
    chk(viol == 0, "R4 request before release", viol, 0);
    chk(done && nvalid == 3, "R4 transfer complete", nvalid, 3);

    // R6: slow first half succeeds under idle limit
    d_lo = 40; d_hi = 1; r_lo = 1; r_hi = 1;
    xfer(2, 2, 0);
    chk(done && !timeout, "R6 long first-half wait", {done, timeout}, 2);
    chk(nvalid == 2, "R6 bytes", nvalid, 2);

    // R6 R7: same delay on second half times out
    d_lo = 1; d_hi = 40;
    xfer(2, 0, 0);
    chk(timeout && !done && !io_error, "R6 second-half limit", {done, timeout, io_error}, 2);
    chk(nvalid == 0, "R7 no partial byte", nvalid, 0);
    chk(n_autofd, "R7 request released", n_autofd, 1);

    // R7: no response at all, timing of idle limit
    d_lo = NEVER; d_hi = 1;
    xfer(1, 0, 0);
    chk(timeout && !done, "R7 timeout on silence", {done, timeout}, 1);
    chk(waited >= IL - 2 && waited <= IL + 3, "R6 idle limit cycles", waited, IL);

    // R8: missed release after a first half -> timeout
    d_lo = 1; d_hi = 1; r_lo = NEVER; r_hi = 1;
    xfer(2, 0, 0);
    chk(timeout && !io_error, "R8 early release miss", {timeout, io_error}, 2);

    // R8: missed release after a non-final second half -> timeout
    r_lo = 1; r_hi = NEVER;
    xfer(2, 1, 0);
    chk(timeout && !io_error && nvalid == 1, "R8 mid release miss", {timeout, io_error}, 2);

    // R8: missed final release -> io_error, byte still delivered
    xfer(1, 1, 0);
    chk(io_error && !timeout && !done, "R8 final release miss", {done, timeout, io_error}, 1);
    chk(nvalid == 1, "R8 byte before error", nvalid, 1);

    // R11: next start clears flags
    r_hi = 1;
    xfer(2, 2, 0);
    chk(done && !timeout && !io_error, "R11 flags cleared", {done, timeout, io_error}, 4);

    // R9: start during transfer ignored
    d_lo = 2; d_hi = 2; r_lo = 2; r_hi = 2;
    xfer(4, 4, 1);
    chk(done && nvalid == 4, "R9 start ignored while busy", nvalid, 4);
    chk(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);

    // R10: zero count
    m_rst = 1;
    nvalid = 0;
    start = 1; byte_count = 0;
    @(negedge clk);
    start = 0;
    chk(done && !timeout && !io_error, "R10 immediate done", {done, timeout, io_error}, 4);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(n_autofd, "R10 no request", n_autofd, 1);
    end
    chk(nvalid == 0, "R10 no bytes", nvalid, 0);
    chk(viol_ctl == 0, "R2 select/strobe high at end", viol_ctl, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule